// File: doc/BRIEF.md
# Wide-Bus Receiver Training Pattern Generator

This block produces the fixed training burst that a sending device places on a wide parallel bus at the start of a double-transition inbound data phase. The receiver uses the burst to tune its equalizer and its per-line skew compensation. Each clock cycle is one transfer slot, which is half of a REQ period at the fast pacing rate. The block drives REQ, SEL, P1, P_CRCA and sixteen data lines. For each of those twenty lines it also gives a strong/weak driver select.

The burst has three sections and five phases in all. Section A first holds SEL alone, then toggles REQ together with every signal in the full group. Section B starts with a quiet stretch in which the full group repeats 1100, then continues that pattern while REQ toggles. Section C plays a 16-slot pattern on every line of the full group. Each group of lines starts the pattern at its own rotation, and REQ keeps toggling. When the burst is over, a one-cycle done pulse is raised and the lines go back to the data path.

Top module: `wbt_train_gen`

## Requirements
- R1: While rst_ni is low, every line output equals its data-path input, and done_o and training_o are 0.
- R2: A start_i sampled high while idle begins training with slot 0 visible in the following cycle. A start_i sampled while training has no effect on the sequence.
- R3: Phase A-hold lasts 32 slots. SEL is 1 and REQ, P1, P_CRCA and DB are 0.
- R4: Phase A-run follows for 128 slots. SEL is 1. REQ and every line of the full group (DB[15:0], P1, P_CRCA) are 1 on even slots and 0 on odd slots, counted from the start of the phase.
- R5: Phase B-quiet follows for 16 slots. SEL and REQ are 0. The full group repeats 1,1,0,0 starting at the start of the phase.
- R6: Phase B-run follows for 48 slots. SEL is 0 and REQ toggles starting at 1. The full group continues the 1100 cycle without a break, so it is at position (slot+16) mod 4.
- R7: Section C follows for 128 slots, which is eight passes of the pattern 0000010011111011, played MSB first. SEL is 0 and REQ toggles starting at 1. Full-group line n is indexed 0..15 for DB, 16 for P1 and 17 for P_CRCA. In slot s it carries pattern bit (s + 2*(n mod 8)) mod 16.
- R8: With pcomp_en_i high, strong_o[n] is 1 when line n differs from its value in the previous cycle and 0 when it holds. The line order is DB 0..15, P1 16, P_CRCA 17, REQ 18, SEL 19.
- R9: With pcomp_en_i low, every bit of strong_o is 1.
- R10: training_o is high for exactly 352 cycles. In the cycle after the last section C slot, done_o is high for that single cycle and the lines equal the data-path inputs again. The lines also equal the data-path inputs at every other idle time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slot clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch the training burst |
| pcomp_en_i | input | 1 | Precompensation enable |
| dp_db_i | input | 16 | Data-path value for DB |
| dp_p1_i | input | 1 | Data-path value for P1 |
| dp_pcrca_i | input | 1 | Data-path value for P_CRCA |
| dp_req_i | input | 1 | Data-path value for REQ |
| dp_sel_i | input | 1 | Data-path value for SEL |
| db_o | output | 16 | Data line drive |
| p1_o | output | 1 | P1 drive |
| pcrca_o | output | 1 | P_CRCA drive |
| req_o | output | 1 | REQ drive |
| sel_o | output | 1 | SEL drive |
| strong_o | output | 20 | Per-line strong drive select |
| training_o | output | 1 | Training burst in progress |
| done_o | output | 1 | One-cycle end-of-training pulse |

## Verification
The hardest conditions to reach are the phase seams and the hand-back edge. At each of these points the per-line strength select must compare a value from one source against a value from another source. The stimulus changes the data-path inputs randomly every cycle so that both sides of the hand-back are live. It also sends extra start pulses at random points during training to show that they are ignored, and it changes pcomp_en_i between bursts. Every cycle is compared with a slot-indexed reference model of the whole burst.

// File: rtl/wbt_pkg.sv
package wbt_pkg;
  typedef enum logic [2:0] {
    SEC_IDLE, SEC_A_HOLD, SEC_A_RUN, SEC_B_QUIET, SEC_B_RUN, SEC_C_RUN
  } sec_e;

  localparam int unsigned NUM_DB     = 16;
  localparam int unsigned GRP_W      = NUM_DB + 2;
  localparam int unsigned LINE_P1    = NUM_DB;
  localparam int unsigned LINE_PCRCA = NUM_DB + 1;
  localparam int unsigned LINE_REQ   = NUM_DB + 2;
  localparam int unsigned LINE_SEL   = NUM_DB + 3;
  localparam int unsigned NUM_LINES  = NUM_DB + 4;

  localparam int unsigned PAT_LEN = 16;
  localparam logic [PAT_LEN-1:0] C_PATTERN = 16'b0000_0100_1111_1011;
endpackage

// File: rtl/wbt_seq_ctrl.sv
module wbt_seq_ctrl
  import wbt_pkg::*;
#(
  parameter int unsigned LEN_A_HOLD  = 32,
  parameter int unsigned LEN_A_RUN   = 128,
  parameter int unsigned LEN_B_QUIET = 16,
  parameter int unsigned LEN_B_RUN   = 48,
  parameter int unsigned LEN_C_RUN   = 128,
  parameter int unsigned SLOT_W      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output sec_e              sec_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              done_o
);
  sec_e              sec_q;
  logic [SLOT_W-1:0] slot_q;
  logic              done_q;
  logic [SLOT_W-1:0] last_slot;

  always_comb begin
    unique case (sec_q)
      SEC_A_HOLD:  last_slot = SLOT_W'(LEN_A_HOLD - 1);
      SEC_A_RUN:   last_slot = SLOT_W'(LEN_A_RUN - 1);
      SEC_B_QUIET: last_slot = SLOT_W'(LEN_B_QUIET - 1);
      SEC_B_RUN:   last_slot = SLOT_W'(LEN_B_RUN - 1);
      SEC_C_RUN:   last_slot = SLOT_W'(LEN_C_RUN - 1);
      default:     last_slot = '0;
    endcase
  end

  wire at_end = (sec_q != SEC_IDLE) && (slot_q == last_slot);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q  <= SEC_IDLE;
      slot_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (sec_q == SEC_IDLE) begin
        if (start_i) begin
          sec_q  <= SEC_A_HOLD;
          slot_q <= '0;
        end
      end else if (at_end) begin
        slot_q <= '0;
        unique case (sec_q)
          SEC_A_HOLD:  sec_q <= SEC_A_RUN;
          SEC_A_RUN:   sec_q <= SEC_B_QUIET;
          SEC_B_QUIET: sec_q <= SEC_B_RUN;
          SEC_B_RUN:   sec_q <= SEC_C_RUN;
          default: begin
            sec_q  <= SEC_IDLE;
            done_q <= 1'b1;
          end
        endcase
      end else begin
        slot_q <= slot_q + 1'b1;
      end
    end
  end

  assign sec_o  = sec_q;
  assign slot_o = slot_q;
  assign done_o = done_q;

  // R3
  a_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_q == SEC_A_HOLD |=> (sec_q == SEC_A_HOLD || sec_q == SEC_A_RUN));
  // R5
  b_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_q == SEC_B_QUIET |=> (sec_q == SEC_B_QUIET || sec_q == SEC_B_RUN));
  // R2
  start_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_q != SEC_IDLE) && start_i && !at_end |=> slot_q == $past(slot_q) + 1'b1);
  // R10
  c_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_q == SEC_C_RUN) && at_end |=> done_q && sec_q == SEC_IDLE);
  // R10
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
endmodule

// File: rtl/wbt_pattern_gen.sv
module wbt_pattern_gen
  import wbt_pkg::*;
#(
  parameter int unsigned LEN_B_QUIET = 16,
  parameter int unsigned PHASE_STEP  = 2,
  parameter int unsigned PHASE_SETS  = 8,
  parameter int unsigned SLOT_W      = 8
) (
  input  sec_e                 sec_i,
  input  logic [SLOT_W-1:0]    slot_i,
  output logic [NUM_LINES-1:0] lines_o
);
  localparam int unsigned IDX_W = $clog2(PAT_LEN);

  logic              toggle;
  logic              b_bit;
  logic [SLOT_W-1:0] b_pos;
  logic [GRP_W-1:0]  c_bits;

  assign toggle = ~slot_i[0];
  assign b_pos  = slot_i + ((sec_i == SEC_B_RUN) ? SLOT_W'(LEN_B_QUIET) : '0);
  assign b_bit  = ~b_pos[1];

  for (genvar n = 0; n < GRP_W; n++) begin : g_c_line
    localparam int unsigned OFF = (PHASE_STEP * (n % PHASE_SETS)) % PAT_LEN;
    logic [IDX_W-1:0] idx;
    assign idx       = slot_i[IDX_W-1:0] + IDX_W'(OFF);
    assign c_bits[n] = C_PATTERN[PAT_LEN-1-idx];
  end

  always_comb begin
    lines_o = '0;
    unique case (sec_i)
      SEC_A_HOLD: lines_o[LINE_SEL] = 1'b1;
      SEC_A_RUN: begin
        lines_o[LINE_SEL]    = 1'b1;
        lines_o[LINE_REQ]    = toggle;
        lines_o[GRP_W-1:0]   = {GRP_W{toggle}};
      end
      SEC_B_QUIET: lines_o[GRP_W-1:0] = {GRP_W{b_bit}};
      SEC_B_RUN: begin
        lines_o[LINE_REQ]  = toggle;
        lines_o[GRP_W-1:0] = {GRP_W{b_bit}};
      end
      SEC_C_RUN: begin
        lines_o[LINE_REQ]  = toggle;
        lines_o[GRP_W-1:0] = c_bits;
      end
      default: lines_o = '0;
    endcase
  end
endmodule

// File: rtl/wbt_drive_sel.sv
module wbt_drive_sel
  import wbt_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 pcomp_en_i,
  input  logic [NUM_LINES-1:0] lines_i,
  output logic [NUM_LINES-1:0] strong_o
);
  logic [NUM_LINES-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lines_i;
  end

  assign strong_o = pcomp_en_i ? (lines_i ^ prev_q) : '1;

  // R8
  hold_weak_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pcomp_en_i && (lines_i == prev_q) |-> strong_o == '0);
endmodule

// File: rtl/wbt_train_gen.sv
module wbt_train_gen
  import wbt_pkg::*;
#(
  parameter int unsigned LEN_A_HOLD  = 32,
  parameter int unsigned LEN_A_RUN   = 128,
  parameter int unsigned LEN_B_QUIET = 16,
  parameter int unsigned LEN_B_RUN   = 48,
  parameter int unsigned LEN_C_RUN   = 128,
  parameter int unsigned PHASE_STEP  = 2,
  parameter int unsigned PHASE_SETS  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              pcomp_en_i,
  input  logic [NUM_DB-1:0] dp_db_i,
  input  logic              dp_p1_i,
  input  logic              dp_pcrca_i,
  input  logic              dp_req_i,
  input  logic              dp_sel_i,
  output logic [NUM_DB-1:0] db_o,
  output logic              p1_o,
  output logic              pcrca_o,
  output logic              req_o,
  output logic              sel_o,
  output logic [NUM_LINES-1:0] strong_o,
  output logic              training_o,
  output logic              done_o
);
  localparam int unsigned MAX_LEN_AB = (LEN_A_HOLD > LEN_A_RUN) ? LEN_A_HOLD : LEN_A_RUN;
  localparam int unsigned MAX_LEN_B  = (LEN_B_QUIET > LEN_B_RUN) ? LEN_B_QUIET : LEN_B_RUN;
  localparam int unsigned MAX_LEN_X  = (MAX_LEN_AB > MAX_LEN_B) ? MAX_LEN_AB : MAX_LEN_B;
  localparam int unsigned MAX_LEN    = (MAX_LEN_X > LEN_C_RUN) ? MAX_LEN_X : LEN_C_RUN;
  localparam int unsigned SLOT_W     = $clog2(MAX_LEN + LEN_B_QUIET) + 1;

  sec_e                 sec;
  logic [SLOT_W-1:0]    slot;
  logic [NUM_LINES-1:0] pat_lines, dp_lines, lines;

  wbt_seq_ctrl #(
    .LEN_A_HOLD(LEN_A_HOLD), .LEN_A_RUN(LEN_A_RUN), .LEN_B_QUIET(LEN_B_QUIET),
    .LEN_B_RUN(LEN_B_RUN), .LEN_C_RUN(LEN_C_RUN), .SLOT_W(SLOT_W)
  ) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .sec_o(sec), .slot_o(slot), .done_o(done_o)
  );

  wbt_pattern_gen #(
    .LEN_B_QUIET(LEN_B_QUIET), .PHASE_STEP(PHASE_STEP),
    .PHASE_SETS(PHASE_SETS), .SLOT_W(SLOT_W)
  ) u_pat (
    .sec_i(sec), .slot_i(slot), .lines_o(pat_lines)
  );

  assign dp_lines   = {dp_sel_i, dp_req_i, dp_pcrca_i, dp_p1_i, dp_db_i};
  assign training_o = (sec != SEC_IDLE);
  assign lines      = training_o ? pat_lines : dp_lines;

  wbt_drive_sel u_drv (
    .clk_i(clk_i), .rst_ni(rst_ni), .pcomp_en_i(pcomp_en_i),
    .lines_i(lines), .strong_o(strong_o)
  );

  assign db_o    = lines[NUM_DB-1:0];
  assign p1_o    = lines[LINE_P1];
  assign pcrca_o = lines[LINE_PCRCA];
  assign req_o   = lines[LINE_REQ];
  assign sel_o   = lines[LINE_SEL];

  // R10
  handback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !training_o && lines == dp_lines);
  // R7
  c_sel_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec == SEC_C_RUN |-> !sel_o);
endmodule

// File: tb/tb_wbt_train_gen.sv
`timescale 1ns/1ps
module tb_wbt_train_gen;
  localparam int TOTAL = 352;
  localparam logic [15:0] PAT = 16'b0000010011111011;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, pcomp = 1'b0;
  logic [19:0] dp = '0;
  logic [15:0] db_o;
  logic p1_o, pcrca_o, req_o, sel_o, training_o, done_o;
  logic [19:0] strong_o;

  int errors = 0, checks = 0;
  bit m_act = 0, m_done = 0;
  int m_k = 0;
  logic [19:0] prev_exp = '0;

  always #2.5 clk = ~clk;

  wbt_train_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .pcomp_en_i(pcomp),
    .dp_db_i(dp[15:0]), .dp_p1_i(dp[16]), .dp_pcrca_i(dp[17]),
    .dp_req_i(dp[18]), .dp_sel_i(dp[19]),
    .db_o(db_o), .p1_o(p1_o), .pcrca_o(pcrca_o), .req_o(req_o), .sel_o(sel_o),
    .strong_o(strong_o), .training_o(training_o), .done_o(done_o)
  );

  function automatic logic [19:0] gold(int k);
    logic [19:0] v = '0;
    int s;
    if (k < 32) v[19] = 1'b1;
    else if (k < 160) begin
      s = k - 32; v[19] = 1'b1; v[18] = (s % 2 == 0);
      for (int n = 0; n < 18; n++) v[n] = (s % 2 == 0);
    end else if (k < 176) begin
      s = k - 160;
      for (int n = 0; n < 18; n++) v[n] = (s % 4 < 2);
    end else if (k < 224) begin
      s = k - 176; v[18] = (s % 2 == 0);
      for (int n = 0; n < 18; n++) v[n] = ((s + 16) % 4 < 2);
    end else begin
      s = k - 224; v[18] = (s % 2 == 0);
      for (int n = 0; n < 18; n++) v[n] = PAT[15 - ((s + 2 * (n % 8)) % 16)];
    end
    return v;
  endfunction

  function automatic string tag_of(int k);
    if (k < 32) return "R3";
    if (k < 160) return "R4";
    if (k < 176) return "R5";
    if (k < 224) return "R6";
    return "R7";
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act <= 0; m_k <= 0; m_done <= 0;
    end else begin
      m_done <= 0;
      if (m_act) begin
        if (m_k == TOTAL - 1) begin m_act <= 0; m_done <= 1; end
        else m_k <= m_k + 1;
      end else if (start) begin
        m_act <= 1; m_k <= 0;
      end
    end
  end

  always @(negedge clk) begin
    logic [19:0] got, exp_l, exp_s;
    got = {sel_o, req_o, pcrca_o, p1_o, db_o};
    if (!rst_n) begin
      chk(got == dp && !done_o && !training_o, "R1", "reset state",
          {got, done_o, training_o}, {dp, 2'b00});
      prev_exp = '0;
    end else begin
      exp_l = m_act ? gold(m_k) : dp;
      chk(got == exp_l, m_act ? tag_of(m_k) : "R10", "lines", got, exp_l);
      chk(training_o == m_act && done_o == m_done, "R10", "training/done",
          {training_o, done_o}, {m_act, m_done});
      exp_s = pcomp ? (exp_l ^ prev_exp) : '1;
      chk(strong_o == exp_s, pcomp ? "R8" : "R9", "strong", strong_o, exp_s);
      prev_exp = exp_l;
    end
  end

  task automatic cyc(bit st);
    @(posedge clk); #1;
    start = st;
    dp = 20'($urandom);
  endtask

  task automatic burst(bit pc, bit noisy);
    pcomp = pc;
    cyc(1'b1);
    for (int i = 0; i < TOTAL + 1; i++) begin
      bit st;
      st = noisy && ($urandom % 7 == 0);
      if (i == TOTAL - 1) st = 1'b0;
      cyc(st);
      if (st) begin
        @(negedge clk);
        chk(training_o == 1'b1, "R2", "start during training ignored", training_o, 1);
      end
    end
    for (int i = 0; i < 5; i++) cyc(1'b0);
  endtask

  initial begin
    bit timeout = 0;
    void'($urandom(32'h5eed1234));
    fork
      begin
        dp = 20'($urandom);
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        for (int i = 0; i < 4; i++) cyc(1'b0);
        burst(1'b1, 1'b0);
        burst(1'b0, 1'b1);
        burst(1'($urandom), 1'b1);
        pcomp = 1'b1;
        cyc(1'b1);
        cyc(1'b1);
        for (int i = 0; i < TOTAL + 4; i++) cyc(1'b0);
      end
      begin
        #(200000 * 5);
        timeout = 1;
      end
    join_any
    disable fork;
    if (timeout) chk(1'b0, "R10", "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule